// File: doc/BRIEF.md
# Sign-Skewer Projection Array

This block projects a stream of pixel spectra onto a bank of random directions whose components are all plus or minus one. Each pixel arrives as a run of band samples, one sample per accepted clock. The sample is broadcast to every lane, and each lane also receives its own skewer sign bit for that band. Because a skewer component is only +1 or -1, a lane needs no multiplier. It adds or subtracts the sample into a signed accumulator.

When the last band of a pixel has been taken, the block spends one update clock. In that clock every lane compares its projection with the extremes it has seen so far in the pass. It stores the new extreme value and the pixel's position whenever the projection beats the stored value. Once the last pixel of the image has been folded in, a one-clock done pulse marks that the per-lane minimum and maximum pixel indices are final. A purity-counting stage downstream would read these indices. The next accepted sample then starts a new pass.

Top module: `skewer_proj_array`

## Requirements
- R1: A skewer bit of 1 adds the band sample (an unsigned `SAMPLE_W`-bit value) to the lane's projection, and a bit of 0 subtracts it. Bit `l` of `in_signs` belongs to lane `l`.
- R2: Every lane receives the same `in_sample` in the same clock. Each lane uses only its own sign bit, so lanes with different skewers reach independent results for the same pixel.
- R3: A sample is consumed only in a clock where both `in_valid` and `in_ready` are high. Clocks with `in_valid` low leave every projection unchanged.
- R4: After the `BANDS`-th sample of a pixel is accepted, `in_ready` is low for exactly one clock (the update clock) and then returns high.
- R5: In the update clock, a projection strictly greater than the stored maximum replaces it and records the pixel index. A projection strictly less than the stored minimum does the same for the minimum. On ties the earlier index is kept.
- R6: The first pixel of a pass (index 0) sets both minimum and maximum unconditionally.
- R7: `done` is high for exactly one clock, the clock after the update clock of pixel `PIXELS-1`. At that point `min_idx` and `max_idx` hold the final results. The indices change only in the clock that follows an update clock.
- R8: After a pass ends, the next pixel has index 0 and starts a fresh pass, with no influence from the previous image.
- R9: After reset, `in_ready` is high, `done` is low and all indices are zero.
- R10: The accumulator holds `SAMPLE_W + clog2(BANDS) + 1` signed bits, so full-scale samples on every band neither overflow nor wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Band sample is present |
| in_ready | output | 1 | Block can take a sample this clock |
| in_sample | input | SAMPLE_W | Unsigned band sample, broadcast to all lanes |
| in_signs | input | LANES | Per-lane skewer sign for this band (1 = add) |
| done | output | 1 | One-clock pulse when the pass results are final |
| min_idx | output | LANES*IDX_W | Per-lane index of the minimum-projection pixel, lane l at bits [l*IDX_W +: IDX_W] |
| max_idx | output | LANES*IDX_W | Per-lane index of the maximum-projection pixel, same packing |

## Verification
Some properties hold on every clock, and the assertions check these. The ready signal never drops for two clocks in a row. Done is a single-clock pulse that always follows a clock with ready low. The index outputs stay still after any clock in which the block was accepting samples.

The arithmetic can only be shown by the bench scenarios. These cover add and subtract per lane, tie handling, re-initialisation at each pass, stall tolerance and full-scale sums. In each one the bench computes every lane's projections and compares the expected extreme indices with the outputs at the done pulse.

// File: rtl/skp_pkg.sv
package skp_pkg;
    typedef enum logic {PH_ACC = 1'b0, PH_UPD = 1'b1} phase_e;
endpackage

// File: rtl/skp_ctrl.sv
module skp_ctrl #(
    parameter int BANDS  = 4,
    parameter int PIXELS = 8,
    localparam int BAND_W = (BANDS > 1) ? $clog2(BANDS) : 1,
    localparam int IDX_W  = (PIXELS > 1) ? $clog2(PIXELS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             acc_en,
    output logic             update,
    output logic             first,
    output logic [IDX_W-1:0] pix_idx,
    output logic             done
);
    import skp_pkg::*;

    typedef struct packed {
        phase_e              phase;
        logic [BAND_W-1:0]   band;
        logic [IDX_W-1:0]    pix;
        logic                done;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        in_ready  = (st_q.phase == PH_ACC);
        acc_en    = in_valid && in_ready;
        update    = (st_q.phase == PH_UPD);
        if (acc_en) begin
            if (st_q.band == BAND_W'(BANDS - 1)) begin
                st_d.band  = '0;
                st_d.phase = PH_UPD;
            end else begin
                st_d.band = st_q.band + 1'b1;
            end
        end
        if (update) begin
            st_d.phase = PH_ACC;
            if (st_q.pix == IDX_W'(PIXELS - 1)) begin
                st_d.pix  = '0;
                st_d.done = 1'b1;
            end else begin
                st_d.pix = st_q.pix + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{phase: PH_ACC, band: '0, pix: '0, done: 1'b0};
        else        st_q <= st_d;
    end

    assign first   = (st_q.pix == '0);
    assign pix_idx = st_q.pix;
    assign done    = st_q.done;
endmodule

// File: rtl/skp_lane.sv
module skp_lane #(
    parameter int SAMPLE_W = 8,
    parameter int ACC_W    = 11,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_en,
    input  logic                sign,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                update,
    input  logic                first,
    input  logic [IDX_W-1:0]    pix_idx,
    output logic [IDX_W-1:0]    min_idx,
    output logic [IDX_W-1:0]    max_idx
);
    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ACC_W-1:0] min_v;
        logic signed [ACC_W-1:0] max_v;
        logic [IDX_W-1:0]        min_i;
        logic [IDX_W-1:0]        max_i;
    } lane_t;

    lane_t ln_d, ln_q;
    logic signed [ACC_W-1:0] ext;

    assign ext = {{(ACC_W - SAMPLE_W){1'b0}}, sample};

    always_comb begin
        ln_d = ln_q;
        if (acc_en) begin
            ln_d.acc = sign ? (ln_q.acc + ext) : (ln_q.acc - ext);
        end
        if (update) begin
            if (first || (ln_q.acc > ln_q.max_v)) begin
                ln_d.max_v = ln_q.acc;
                ln_d.max_i = pix_idx;
            end
            if (first || (ln_q.acc < ln_q.min_v)) begin
                ln_d.min_v = ln_q.acc;
                ln_d.min_i = pix_idx;
            end
            ln_d.acc = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ln_q <= '0;
        else        ln_q <= ln_d;
    end

    assign min_idx = ln_q.min_i;
    assign max_idx = ln_q.max_i;
endmodule

// File: rtl/skewer_proj_array.sv
module skewer_proj_array #(
    parameter int LANES    = 4,
    parameter int BANDS    = 4,
    parameter int SAMPLE_W = 8,
    parameter int PIXELS   = 8,
    localparam int IDX_W   = (PIXELS > 1) ? $clog2(PIXELS) : 1,
    localparam int ACC_W   = SAMPLE_W + $clog2(BANDS) + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [SAMPLE_W-1:0]    in_sample,
    input  logic [LANES-1:0]       in_signs,
    output logic                   done,
    output logic [LANES*IDX_W-1:0] min_idx,
    output logic [LANES*IDX_W-1:0] max_idx
);
    logic             acc_en, update, first;
    logic [IDX_W-1:0] pix_idx;

    skp_ctrl #(.BANDS(BANDS), .PIXELS(PIXELS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .acc_en(acc_en), .update(update), .first(first),
        .pix_idx(pix_idx), .done(done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        skp_lane #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) lane_i (
            .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .sign(in_signs[l]),
            .sample(in_sample), .update(update), .first(first),
            .pix_idx(pix_idx),
            .min_idx(min_idx[l*IDX_W +: IDX_W]),
            .max_idx(max_idx[l*IDX_W +: IDX_W])
        );
    end
endmodule

// File: rtl/skp_checker.sv
module skp_checker #(
    parameter int FLAT_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              done,
    input logic [FLAT_W-1:0] min_idx,
    input logic [FLAT_W-1:0] max_idx
);
    assert_ready_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> in_ready);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !$past(in_ready));

    assert_idx_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> ($stable(min_idx) && $stable(max_idx)));

    assert_ready_at_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> in_ready);
endmodule

bind skewer_proj_array skp_checker #(.FLAT_W(LANES*IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .done(done),
    .min_idx(min_idx), .max_idx(max_idx)
);

// File: tb/skewer_proj_array_tb.sv
module skewer_proj_array_tb_top;
    localparam int LANES = 4;
    localparam int BANDS = 4;
    localparam int SW    = 8;
    localparam int PIX   = 8;
    localparam int IW    = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [SW-1:0]     in_sample = '0;
    logic [LANES-1:0]  in_signs = '0;
    logic              done;
    logic [LANES*IW-1:0] min_idx, max_idx;

    int checks = 0;
    int failures = 0;
    logic [31:0] rng = 32'h1234_5678;
    int smp [PIX][BANDS];
    logic [BANDS-1:0] sk [LANES];

    always #2.5 clk = ~clk;

    skewer_proj_array #(.LANES(LANES), .BANDS(BANDS), .SAMPLE_W(SW), .PIXELS(PIX)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_sample(in_sample), .in_signs(in_signs), .done(done),
        .min_idx(min_idx), .max_idx(max_idx)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int next_rand();
        rng = rng * 32'd1103515245 + 32'd12345;
        return int'(rng[23:16]);
    endfunction

    task automatic send(input int s, input logic [LANES-1:0] sg, input int idle);
        repeat (idle) @(negedge clk);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_sample = SW'(s); in_signs = sg;
        @(posedge clk);
        #1 in_valid = 1'b0; in_sample = '0; in_signs = '0;
    endtask

    // Sends one image, then checks the update gap, done pulse and per-lane extremes
    task automatic run_image(input string tag, input int stall);
        for (int p = 0; p < PIX; p++) begin
            for (int b = 0; b < BANDS; b++) begin
                logic [LANES-1:0] sg;
                for (int l = 0; l < LANES; l++) sg[l] = sk[l][b];
                send(smp[p][b], sg, (stall != 0) ? ((p + b) % 3) : 0);
            end
            if (p == PIX - 1) begin
                @(negedge clk);
                check({"R4 ready low in update clock ", tag}, int'(in_ready), 0);
                @(negedge clk);
                check({"R7 done pulse ", tag}, int'(done), 1);
            end
        end
        for (int l = 0; l < LANES; l++) begin
            int proj [PIX];
            int bmax, bmin;
            for (int p = 0; p < PIX; p++) begin
                proj[p] = 0;
                for (int b = 0; b < BANDS; b++)
                    proj[p] += sk[l][b] ? smp[p][b] : -smp[p][b];
            end
            bmax = 0; bmin = 0;
            for (int p = 1; p < PIX; p++) begin
                if (proj[p] > proj[bmax]) bmax = p;
                if (proj[p] < proj[bmin]) bmin = p;
            end
            check({"R1 R2 R5 R6 max index ", tag}, int'(max_idx[l*IW +: IW]), bmax);
            check({"R1 R2 R5 R6 min index ", tag}, int'(min_idx[l*IW +: IW]), bmin);
        end
        @(negedge clk);
        check({"R7 done single clock ", tag}, int'(done), 0);
    endtask

    task automatic set_skewers();
        sk[0] = '1;
        sk[1] = '0;
        for (int l = 2; l < LANES; l++) sk[l] = BANDS'(next_rand());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R9 reset ready", int'(in_ready), 1);
        check("R9 reset done", int'(done), 0);
        check("R9 reset min_idx", int'(min_idx), 0);
        check("R9 reset max_idx", int'(max_idx), 0);
        rst_n = 1'b1;

        // random spectra, random skewers
        set_skewers();
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++) smp[p][b] = next_rand();
        run_image("random", 0);

        // equal pixels: ties keep index 0, new pass re-initialises (R5 R6 R8)
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++) smp[p][b] = 100;
        run_image("ties R8", 0);

        // ramp across pixels: add lane max last, subtract lane max first
        set_skewers();
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++) smp[p][b] = p * 36;
        run_image("ramp", 0);

        // random spectra with idle input clocks between samples (R3)
        set_skewers();
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++) smp[p][b] = next_rand();
        run_image("stall R3", 1);

        // full-scale pixel among small ones: no wrap of the sum (R10)
        set_skewers();
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++)
            smp[p][b] = (p == 3) ? 255 : (next_rand() % 16);
        run_image("fullscale R10", 0);

        // full-scale on the last pixel, zero elsewhere
        set_skewers();
        for (int p = 0; p < PIX; p++) for (int b = 0; b < BANDS; b++)
            smp[p][b] = (p == PIX - 1) ? 255 : 0;
        run_image("fullscale last R10", 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule